// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave

This block is the configuration port of a clock generator. It is a slave on a two-wire serial bus that holds thirteen 8-bit registers. These registers control output enables, the frequency selection source, spread spectrum and output skew. Both bus lines are brought into the system clock domain and their edges are detected there. The block recognises start and stop conditions, compares the address against its own, and answers with open-drain acknowledge bits.

A write must carry two leading bytes after the address: a command code and a byte count. Both are acknowledged and then thrown away. The data that follows always fills the bank from the first register upward, one register per byte. A read returns the bank from the first register upward while the master keeps acknowledging. Every register value drives a parallel output that the clock generator uses.

Five frequency-select strap pins are captured while reset is held. Their values appear in the upper bits of register 1. Two identification registers at the top of the bank hold fixed values.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper 7 bits equal `SLAVE_ADDR`. After any other address it drives nothing and changes no register until the next start condition.
- R2: In a write, the two bytes that follow the address are acknowledged and change no register.
- R3: Each later data byte of a write is acknowledged and stored into registers 0, 1, 2 and onward, in that order. Register contents change only while SCL is low.
- R4: Reset gives these values: register 0 = 0x00, register 1 low bits [2:0] = 3'b001, registers 2 to 4 = 0xFF, register 5 = 0x93, registers 6 to 10 = 0x00, register 11 = 0x50, register 12 = 0x12.
- R5: Register 1 bits [7:3] show the `strap_sel` value sampled while `rst_n` was low. Writes do not alter them, and neither do later strap changes. Only bits [2:0] are writable.
- R6: Registers 11 and 12 are read-only. Writes that reach them are acknowledged and have no effect.
- R7: Data bytes beyond register 12 are acknowledged and discarded.
- R8: A read address (R/W bit 1) returns register 0, then 1 and onward, MSB first. The slave goes on after a master ACK (SDA low) and releases SDA for good after a master NACK.
- R9: A stop condition or a repeated start sends the next write's data to register 0 again. Register contents are kept across both.
- R10: `sda_oe` (1 = pull SDA low) changes only while SCL is low. It is 0 when the bus is idle.
- R11: `cfg_regs` holds register n in bits [8n+7:8n] at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_sel | input | 5 | Frequency-select straps, captured during reset |
| cfg_regs | output | 104 | All thirteen registers, register n in bits [8n+7:8n] |

## Verification
The bench builds the block with the default parameters: own address 0x69 and a two-stage synchroniser. The SCL half period is 20 system clocks, which leaves room for the synchroniser and pipeline latency before the next SCL edge. A single 15-byte write, with the thirteen-register bank, walks the pointer through the writable registers, the two identification registers and past the end of the bank. Repeated starts, stops, a foreign address and read-back with master ACK and NACK each move the pointer along a different path.

// File: rtl/cfgslv_pkg.sv
// Shared constants, types and register-layout functions for the configuration slave.
// Assumes a fixed bank of thirteen registers; register 1 carries the strap field.
package cfgslv_pkg;

    localparam int NUM_REGS  = 13;
    localparam int PTR_W     = $clog2(NUM_REGS + 1);
    localparam int IMG_W     = NUM_REGS * 8;
    localparam int STRAP_REG = 1;
    localparam int STRAP_W   = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_t;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_CMD,
        BY_CNT,
        BY_DATA
    } stage_t;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            1:       return 8'h01;
            2, 3, 4: return 8'hFF;
            5:       return 8'h93;
            11:      return 8'h50;
            12:      return 8'h12;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            STRAP_REG: return 8'h07;
            11, 12:    return 8'h00;
            default:   return 8'hFF;
        endcase
    endfunction

    function automatic logic [IMG_W-1:0] default_image();
        logic [IMG_W-1:0] img;
        img = '0;
        for (int i = 0; i < NUM_REGS; i++) img[i*8 +: 8] = reg_default(i);
        return img;
    endfunction

endpackage

// File: rtl/cfgslv_sync.sv
// Brings one asynchronous bus line into the clk domain and flags its edges.
// Assumes STAGES >= 2; the line idles high, so every flop resets to 1.
module cfgslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the line through the synchroniser and keep one extra history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

endmodule

// File: rtl/cfgslv_link.sv
// Bit and byte engine of the serial slave: start/stop detection, address match,
// dummy command and count bytes, sequential write and read with a shared pointer.
// Assumes synchronised, edge-flagged SCL/SDA; SCL low time exceeds a few clk cycles.
module cfgslv_link
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);

    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

    phase_t           phase;
    stage_t           stage;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [PTR_W-1:0] ptr;
    logic             rnw;
    logic             nack;
    logic             start_c;
    logic             stop_c;
    logic             byte_done;
    logic [PTR_W-1:0] ptr_inc;

    assign start_c   = scl_lvl & sda_fall;
    assign stop_c    = scl_lvl & sda_rise;
    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign ptr_inc   = (ptr == PTR_END) ? ptr : ptr + 1'b1;
    assign rd_idx    = ptr;

    // Protocol state machine: every bus event moves phase, pointer and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            stage   <= BY_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            rnw     <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                phase  <= PH_RX;
                stage  <= BY_ADDR;
                bitcnt <= '0;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                phase  <= PH_IDLE;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            case (stage)
                                BY_ADDR: begin
                                    if (shreg[7:1] == SLAVE_ADDR) begin
                                        rnw    <= shreg[0];
                                        sda_oe <= 1'b1;
                                        phase  <= PH_ACK;
                                    end else begin
                                        phase  <= PH_IDLE;
                                    end
                                end
                                BY_DATA: begin
                                    if (ptr != PTR_END) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_data <= shreg;
                                    end
                                    ptr    <= ptr_inc;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK;
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK;
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (stage == BY_ADDR && rnw) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr_inc;
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                                case (stage)
                                    BY_ADDR: stage <= BY_CMD;
                                    BY_CMD:  stage <= BY_CNT;
                                    default: stage <= BY_DATA;
                                endcase
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_MACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                        end else if (scl_fall) begin
                            if (nack) begin
                                phase <= PH_IDLE;
                            end else begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr_inc;
                                bitcnt <= '0;
                                phase  <= PH_TX;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgslv_regs.sv
// Register bank: per-register defaults and write masks, constant identification
// registers, and strap capture into register 1 while reset is held.
// Assumes one write strobe per data byte with an index below NUM_REGS.
module cfgslv_regs
    import cfgslv_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [STRAP_W-1:0]           strap_sel,
    input  logic                         wr_en,
    input  logic [PTR_W-1:0]             wr_idx,
    input  logic [7:0]                   wr_data,
    output logic [NUM_REGS-1:0][7:0]     image
);

    logic [STRAP_W-1:0] strap_q;

    // Capture the frequency-select straps during reset and hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_sel;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] DEF = reg_default(g);
        localparam logic [7:0] MSK = reg_wmask(g);
        if (MSK == 8'h00) begin : g_const
            assign image[g] = DEF;
        end else begin : g_store
            logic [7:0] q;
            // Load the default on reset, merge writable bits on a matching strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= DEF;
                else if (wr_en && wr_idx == PTR_W'(g)) q <= (q & ~MSK) | (wr_data & MSK);
            end
            if (g == STRAP_REG) begin : g_strap
                assign image[g] = {strap_q, 3'b000} | (q & MSK);
            end else begin : g_plain
                assign image[g] = q;
            end
        end
    end

endmodule

// File: rtl/clkgen_cfg_slave.sv
// Top of the clock generator configuration slave: line synchronisers, protocol
// engine and register bank, with the whole bank exported as a flat vector.
// Assumes open-drain SDA outside the block: sda_oe high means pull low.
module clkgen_cfg_slave
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_sel,
    output logic [IMG_W-1:0]   cfg_regs
);

    logic                     scl_lvl, scl_rise, scl_fall;
    logic                     sda_lvl, sda_rise, sda_fall;
    logic [PTR_W-1:0]         rd_idx;
    logic [7:0]               rd_byte;
    logic                     wr_en;
    logic [PTR_W-1:0]         wr_idx;
    logic [7:0]               wr_data;
    logic [NUM_REGS-1:0][7:0] image;

    cfgslv_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    cfgslv_link #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_data(rd_byte), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe)
    );

    cfgslv_regs u_regs (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .image(image)
    );

    // Read path: past the last register the slave returns all ones.
    assign rd_byte  = (rd_idx < PTR_W'(NUM_REGS)) ? image[rd_idx] : 8'hFF;
    assign cfg_regs = image;

endmodule

// File: rtl/cfgslv_checker.sv
// Temporal checks on the slave's ports, attached to every instance by bind.
// Assumes the SCL low time is longer than the synchroniser plus pipeline delay.
module cfgslv_checker
    import cfgslv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_oe,
    input logic [IMG_W-1:0] cfg_regs
);

    localparam logic [IMG_W-1:0] DEF_IMG  = default_image();
    localparam logic [IMG_W-1:0] DEF_MASK = ~(IMG_W'(8'hF8) << (STRAP_REG * 8));

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(sda_oe)) |-> !scl_in); // R10

    AST_REGS_MOVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(cfg_regs)) |-> !scl_in); // R3

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((cfg_regs & DEF_MASK) == DEF_IMG)); // R4

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_regs[STRAP_REG*8+3 +: STRAP_W])); // R5

endmodule

bind clkgen_cfg_slave cfgslv_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .cfg_regs(cfg_regs)
);

// File: tb/clkgen_cfg_slave_test.sv
// Bench: a behavioural bus master drives the slave, and a register-image model
// is compared against cfg_regs on every clock outside each write's update window.
module clkgen_cfg_slave_test;

    localparam int         HP  = 20;
    localparam logic [6:0] OWN = 7'h69;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [4:0]  straps = 5'b10110;
    logic [4:0]  boot_straps = 5'b10110;
    wire         sda_oe;
    wire         sda_bus = m_sda & ~sda_oe;
    wire [103:0] cfg;

    int          tests = 0;
    int          fails = 0;
    bit          hold_cmp = 1'b0;
    bit          done = 1'b0;
    logic [7:0]  exp_r [13];

    always #2 clk = ~clk;

    clkgen_cfg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .strap_sel(straps), .cfg_regs(cfg)
    );

    function automatic logic [103:0] model_img();
        logic [103:0] v;
        for (int i = 0; i < 13; i++) v[i*8 +: 8] = exp_r[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // R11: register image against model on every clock outside update windows.
    always @(negedge clk) begin
        if (rst_n && !hold_cmp && !done) begin
            tests++;
            if (cfg !== model_img()) begin
                fails++;
                $display("FAIL R11 image: actual 0x%0h expected 0x%0h", cfg, model_img());
            end
        end
    end

    task automatic wait_hp();
        repeat (HP) @(posedge clk);
        #1;
    endtask

    task automatic model_write(input int idx, input logic [7:0] v);
        if (idx == 1) exp_r[1] = {exp_r[1][7:3], v[2:0]};
        else if (idx < 11) exp_r[idx] = v;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_hp();
        m_scl = 1'b1; wait_hp();
        m_sda = 1'b0; wait_hp();
        m_scl = 1'b0; wait_hp();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_hp();
        m_scl = 1'b1; wait_hp();
        m_sda = 1'b1; wait_hp();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit is_data, input int idx,
                             output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_hp();
            m_scl = 1'b1; wait_hp();
            m_scl = 1'b0;
            if (i == 0) hold_cmp = 1'b1;
        end
        m_sda = 1'b1; wait_hp();
        m_scl = 1'b1;
        repeat (HP / 2) @(posedge clk);
        #1;
        ack = !sda_bus;
        if (is_data && ack) model_write(idx, b);
        hold_cmp = 1'b0;
        repeat (HP / 2) @(posedge clk);
        #1;
        m_scl = 1'b0;
    endtask

    task automatic read_byte(input bit m_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_hp();
            m_scl = 1'b1;
            repeat (HP / 2) @(posedge clk);
            #1;
            b[i] = sda_bus;
            repeat (HP / 2) @(posedge clk);
            #1;
            m_scl = 1'b0;
        end
        m_sda = m_ack ? 1'b0 : 1'b1; wait_hp();
        m_scl = 1'b1; wait_hp();
        m_scl = 1'b0; wait_hp();
        m_sda = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                          input logic [7:0] d[$], input bit do_stop);
        bit ack;
        bus_start();
        send_byte({addr, 1'b0}, 1'b0, 0, ack);
        chk(ack == (addr == OWN), "R1", "address acknowledge", int'(ack), int'(addr == OWN));
        if (addr != OWN) begin
            send_byte(8'h00, 1'b0, 0, ack);
            chk(!ack, "R1", "no answer after foreign address", int'(ack), 0);
        end else begin
            send_byte(cmd, 1'b0, 0, ack);
            chk(ack, "R2", "command byte acknowledge", int'(ack), 1);
            send_byte(cnt, 1'b0, 0, ack);
            chk(ack, "R2", "count byte acknowledge", int'(ack), 1);
            foreach (d[i]) begin
                send_byte(d[i], 1'b1, i, ack);
                if (i >= 13)      chk(ack, "R7", "overrun byte acknowledge", int'(ack), 1);
                else if (i >= 11) chk(ack, "R6", "read-only byte acknowledge", int'(ack), 1);
                else              chk(ack, "R3", "data byte acknowledge", int'(ack), 1);
            end
        end
        if (do_stop) bus_stop();
    endtask

    task automatic rd_txn(input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({OWN, 1'b1}, 1'b0, 0, ack);
        chk(ack, "R8", "read address acknowledge", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i < n - 1, b);
            chk(b == exp_r[i], "R8", $sformatf("read byte %0d", i), int'(b), int'(exp_r[i]));
        end
        chk(sda_oe == 1'b0, "R8", "SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R10", "SDA released when idle", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        for (int i = 0; i < 13; i++) exp_r[i] = 8'h00;
        exp_r[1] = {boot_straps, 3'b001};
        exp_r[2] = 8'hFF; exp_r[3] = 8'hFF; exp_r[4] = 8'hFF;
        exp_r[5] = 8'h93; exp_r[11] = 8'h50; exp_r[12] = 8'h12;

        repeat (10) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        // R4: every register at its power-up value.
        for (int i = 0; i < 13; i++) begin
            if (i == 1) chk(cfg[10:8] == 3'b001, "R4", "reg1 low bits", int'(cfg[10:8]), 1);
            else chk(cfg[i*8 +: 8] == exp_r[i], "R4", $sformatf("reg%0d default", i),
                     int'(cfg[i*8 +: 8]), int'(exp_r[i]));
        end
        chk(cfg[15:11] == boot_straps, "R5", "straps latched", int'(cfg[15:11]), int'(boot_straps));
        chk(sda_oe == 1'b0, "R10", "idle after reset", int'(sda_oe), 0);

        // R5: strap pins move after reset, field must not follow.
        straps = 5'b01001;

        // R2, R3: dummy bytes with data-like values, then three data bytes.
        q = '{8'h11, 8'hFF, 8'h0F};
        wr_txn(OWN, 8'hA5, 8'h3C, q, 1'b1);
        chk(cfg[7:0] == 8'h11, "R2", "reg0 took first data, not command", int'(cfg[7:0]), 8'h11);
        chk(cfg[23:16] == 8'h0F, "R3", "reg2 written", int'(cfg[23:16]), 8'h0F);
        chk(cfg[15:8] == {boot_straps, 3'b111}, "R5", "reg1 strap bits kept",
            int'(cfg[15:8]), int'({boot_straps, 3'b111}));

        // R1: foreign address changes nothing.
        q = '{8'h99};
        wr_txn(7'h2A, 8'h00, 8'h00, q, 1'b1);
        chk(cfg[7:0] == 8'h11, "R1", "reg0 after foreign write", int'(cfg[7:0]), 8'h11);

        // R6, R7: run over the whole bank and beyond.
        q = {};
        for (int i = 0; i < 15; i++) q.push_back(8'h80 + 8'(i));
        wr_txn(OWN, 8'h00, 8'h0F, q, 1'b1);
        chk(cfg[95:88] == 8'h50, "R6", "reg11 unchanged", int'(cfg[95:88]), 8'h50);
        chk(cfg[103:96] == 8'h12, "R6", "reg12 unchanged", int'(cfg[103:96]), 8'h12);
        chk(cfg[87:80] == 8'h8A, "R7", "reg10 holds its own byte", int'(cfg[87:80]), 8'h8A);

        // R8: read the whole bank.
        rd_txn(13);

        // R9: repeated start restarts at register 0.
        q = '{8'h5A, 8'h66};
        wr_txn(OWN, 8'h00, 8'h02, q, 1'b0);
        q = '{8'hC3};
        wr_txn(OWN, 8'h00, 8'h01, q, 1'b1);
        chk(cfg[7:0] == 8'hC3, "R9", "repeated start rewinds", int'(cfg[7:0]), 8'hC3);
        chk(cfg[10:8] == 3'b110, "R9", "reg1 kept across repeated start", int'(cfg[10:8]), 6);

        // R9: stop rewinds too.
        q = '{8'h01, 8'h02};
        wr_txn(OWN, 8'h00, 8'h02, q, 1'b1);
        q = '{8'h77};
        wr_txn(OWN, 8'h00, 8'h01, q, 1'b1);
        chk(cfg[7:0] == 8'h77, "R9", "stop rewinds", int'(cfg[7:0]), 8'h77);
        chk(cfg[10:8] == 3'b010, "R9", "reg1 kept across stop", int'(cfg[10:8]), 2);

        // R8: short read ending in NACK after three bytes.
        rd_txn(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule